// File: doc/BRIEF.md
# Retired-Instruction Trace Recorder

This block sits beside a processor core and observes its retirement port. Each cycle in which an instruction retires while capture is on, it builds a packed trace entry and appends it to an on-chip word memory. A plain instruction takes two words. A load or store takes four words, because it also records the computed address and the value seen on the data bus. A debug-note marker takes two words and has its own type tag. The memory is later read out over a simple single-cycle-acknowledge bus slave, either by a debugger or by the processor itself.

Capture is switched on and off by marker no-op instructions, which the core's decoder reports on a 2-bit marker code. Software can therefore bracket the code region it wants traced. The memory runs in one of two modes, chosen by a control bit. In fill mode, logging stops for good at the first entry that does not fit. In wrap mode, the writer restarts at word zero. A small holding queue absorbs the multi-word entries and drains one word per cycle into the memory. Entries that arrive when the queue lacks room are counted and dropped.

Top module: `trace_capture_buf`

## Requirements
- R1: While capture is on, a retirement with marker code 00 and load/store flag 0 stores two words at the next-entry pointer: word 0 holds pc[31:2] in bits 31..2 with type tag 00 in bits 1..0, and word 1 holds the instruction word. The pointer then advances by 2.
- R2: While capture is on, a retirement with marker code 00 and load/store flag 1 stores four words: word 0 with type tag 01, then the instruction word, then the effective address, then the data-bus value. The pointer then advances by 4.
- R3: Marker code 01 turns capture on and marker code 10 turns it off. Neither of these retirements is recorded. A retirement while capture is off writes nothing and leaves the pointer unchanged.
- R4: While capture is on, marker code 11 records a two-word note entry with tag 10 in word 0, followed by the instruction word. The load/store flag is ignored for this entry.
- R5: In fill mode (control bit 0 = 1), an entry that would pass the end of the memory is dropped whole and sets a sticky full flag. Every later entry is then dropped and the pointer stays where it is until a clear.
- R6: In wrap mode (control bit 0 = 0), an entry that would pass the end of the memory is written from word 0 instead. This sets the sticky wrapped flag, and the pointer becomes the entry's size.
- R7: An entry is accepted only if the holding queue's free words, counted at the start of the cycle, are at least the entry size. The queue drains one word per cycle. A rejected entry writes nothing, leaves the pointer and flags unchanged, and increments the saturating overflow count, which is read at register 2.
- R8: When bus address bit AW (= log2 of the memory depth) is 1, a read returns the trace word at the low AW address bits. Otherwise the low two bits select a register: 0 is control, 1 is status, 2 is the overflow count. The acknowledge is a one-cycle pulse in the cycle after the strobe, and read data is valid with it.
- R9: The status register reads as follows: bit 0 is capture on, bit 1 is full, bit 2 is wrapped, bit 3 is the fill-mode bit, and bits 16 and up hold the next-entry pointer.
- R10: A control write with bit 1 set clears the pointer, the full and wrapped flags, the capture-on state, the overflow count and the holding queue. The fill mode takes bit 0 of every control write.
- R11: After reset, the status and overflow registers read 0 and the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_pc | input | 32 | Program counter of the retiring instruction |
| rt_insn | input | 32 | Instruction word |
| rt_ldst | input | 1 | Retiring instruction is a load or store |
| rt_ea | input | 32 | Computed effective address |
| rt_data | input | 32 | Data-bus value of the load or store |
| rt_mark | input | 2 | Marker code: 00 none, 01 on, 10 off, 11 note |
| bus_stb | input | 1 | Bus cycle strobe |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | AW+1 | Bus word address |
| bus_wdat | input | 32 | Bus write data |
| bus_rdat | output | 32 | Bus read data |
| bus_ack | output | 1 | Bus acknowledge |

## Verification
A 16-word memory with an 8-word queue is driven by a sweep over both modes. Each pass uses mixes of plain and load/store entries and inter-retire gaps of zero to two cycles. Spaced entries separate correct packing and tagging from pointer arithmetic. Back-to-back load/stores separate correct queue admission from overflow counting. Long runs hit the end of memory and separate fill-mode freezing from wrap-to-zero placement. Directed runs add off/on/off markers, note markers carrying a set load/store flag, and a clear, so that each gate and flag is compared against an arithmetic model of the memory image, pointer and counters.

// File: rtl/trace_pkg.sv
package trace_pkg;
   typedef enum logic [1:0] {
      TAG_PLAIN = 2'b00,
      TAG_LDST  = 2'b01,
      TAG_NOTE  = 2'b10
   } entry_tag_e;

   typedef enum logic [1:0] {
      MK_NONE = 2'b00,
      MK_ON   = 2'b01,
      MK_OFF  = 2'b10,
      MK_NOTE = 2'b11
   } mark_e;

   localparam int unsigned LANES = 4;
   localparam int unsigned NW_W  = 3;
   localparam logic [1:0]  REG_CTRL = 2'd0;
   localparam logic [1:0]  REG_STAT = 2'd1;
   localparam logic [1:0]  REG_OVF  = 2'd2;
endpackage

// File: rtl/trace_entry_fmt.sv
module trace_entry_fmt
   import trace_pkg::*;
(
   input  logic [31:0]                 pc,
   input  logic [31:0]                 insn,
   input  logic                        ldst,
   input  logic [31:0]                 ea,
   input  logic [31:0]                 data,
   input  mark_e                       mark,
   output logic [LANES-1:0][31:0]      words,
   output logic [NW_W-1:0]             nwords
);
   entry_tag_e tag;

   always_comb begin
      if (mark == MK_NOTE)  tag = TAG_NOTE;
      else if (ldst)        tag = TAG_LDST;
      else                  tag = TAG_PLAIN;
   end

   assign nwords   = (tag == TAG_LDST) ? NW_W'(4) : NW_W'(2);
   assign words[0] = {pc[31:2], tag};
   assign words[1] = insn;
   assign words[2] = ea;
   assign words[3] = data;

   logic unused_pc_low;
   assign unused_pc_low = ^pc[1:0];
endmodule

// File: rtl/trace_alloc.sv
module trace_alloc
   import trace_pkg::*;
#(
   parameter  int unsigned DEPTH = 256,
   localparam int unsigned PW    = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             fill_mode,
   input  logic             rt_valid,
   input  mark_e            mark,
   input  logic [NW_W-1:0]  nwords,
   input  logic             room,
   output logic             push,
   output logic [PW-1:0]    base,
   output logic             ovf_inc,
   output logic [PW-1:0]    ptr,
   output logic             en,
   output logic             full,
   output logic             wrapped
);
   logic want, fits, drop_full;

   assign want      = rt_valid && en && (mark == MK_NONE || mark == MK_NOTE);
   assign fits      = ({1'b0, ptr} + (PW+1)'(nwords)) <= (PW+1)'(DEPTH);
   assign drop_full = fill_mode && (full || !fits);
   assign base      = fits ? ptr : '0;
   assign push      = want && !drop_full && room;
   assign ovf_inc   = want && !drop_full && !room;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ptr     <= '0;
         en      <= 1'b0;
         full    <= 1'b0;
         wrapped <= 1'b0;
      end else begin
         if (rt_valid && mark == MK_ON)  en <= 1'b1;
         if (rt_valid && mark == MK_OFF) en <= 1'b0;
         if (want && fill_mode && !fits) full <= 1'b1;
         if (push) begin
            ptr <= base + PW'(nwords);
            if (!fits) wrapped <= 1'b1;
         end
      end
   end

   // R1
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PW'(DEPTH));
   // R3
   off_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !push);
   // R5
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !clr) |=> full);
   // R5
   full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && fill_mode && !clr) |=> $stable(ptr));
   // R6
   wrapped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped && !clr) |=> wrapped);
endmodule

// File: rtl/trace_hold_fifo.sv
module trace_hold_fifo
   import trace_pkg::*;
#(
   parameter  int unsigned DW    = 40,
   parameter  int unsigned DEPTH = 8,
   localparam int unsigned FAW   = $clog2(DEPTH),
   localparam int unsigned CW    = FAW + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      push,
   input  logic [NW_W-1:0]           push_n,
   input  logic [LANES-1:0][DW-1:0]  push_data,
   output logic [CW-1:0]             free,
   output logic                      pop_vld,
   output logic [DW-1:0]             pop_data
);
   logic [DW-1:0]  mem [DEPTH];
   logic [FAW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0]  count;
   logic [NW_W-1:0] n_eff;

   assign n_eff    = push ? push_n : '0;
   assign free     = CW'(DEPTH) - count;
   assign pop_vld  = (count != '0);
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         for (int i = 0; i < LANES; i++) begin
            if (NW_W'(i) < push_n) mem[wr_ptr + FAW'(i)] <= push_data[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + FAW'(n_eff);
         if (pop_vld) rd_ptr <= rd_ptr + FAW'(1);
         count  <= count + CW'(n_eff) - CW'(pop_vld);
      end
   end

   // R7
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R7
   push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (CW'(push_n) <= free));
endmodule

// File: rtl/trace_word_ram.sv
module trace_word_ram #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [1 << AW];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
   import trace_pkg::*;
#(
   parameter  int unsigned DEPTH      = 256,
   parameter  int unsigned FIFO_DEPTH = 8,
   parameter  int unsigned OVF_W      = 16,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned PW         = AW + 1,
   localparam int unsigned BAW        = AW + 1,
   localparam int unsigned QDW        = AW + 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rt_valid,
   input  logic [31:0]     rt_pc,
   input  logic [31:0]     rt_insn,
   input  logic            rt_ldst,
   input  logic [31:0]     rt_ea,
   input  logic [31:0]     rt_data,
   input  logic [1:0]      rt_mark,
   input  logic            bus_stb,
   input  logic            bus_we,
   input  logic [BAW-1:0]  bus_adr,
   input  logic [31:0]     bus_wdat,
   output logic [31:0]     bus_rdat,
   output logic            bus_ack
);
   if ((1 << AW) != DEPTH || DEPTH < 8 || PW > 16) begin : g_bad_depth
      $error("DEPTH must be a power of two between 8 and 32768");
   end
   if ((1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH || FIFO_DEPTH < 8) begin : g_bad_fifo
      $error("FIFO_DEPTH must be a power of two of at least 8");
   end
   if (OVF_W < 1 || OVF_W > 32) begin : g_bad_ovf
      $error("OVF_W must lie in 1..32");
   end

   localparam int unsigned FCW = $clog2(FIFO_DEPTH) + 1;

   mark_e                   mark;
   logic [LANES-1:0][31:0]  words;
   logic [NW_W-1:0]         nwords;
   logic [LANES-1:0][QDW-1:0] lanes;
   logic [FCW-1:0]          q_free;
   logic                    room, push, ovf_inc, en, full, wrapped;
   logic [PW-1:0]           base, ptr;
   logic                    q_vld;
   logic [QDW-1:0]          q_data;
   logic [31:0]             ram_q;
   logic                    fill_q, ack_q, rsel_ram_q;
   logic [31:0]             reg_q, stat_word, reg_mux;
   logic [OVF_W-1:0]        ovf_q;
   logic                    bus_go, ctrl_wr, clr;

   assign mark    = mark_e'(rt_mark);
   assign bus_go  = bus_stb && !ack_q;
   assign ctrl_wr = bus_go && bus_we && !bus_adr[AW] && bus_adr[1:0] == REG_CTRL;
   assign clr     = ctrl_wr && bus_wdat[1];
   assign room    = FCW'(nwords) <= q_free;

   trace_entry_fmt u_fmt (
      .pc(rt_pc), .insn(rt_insn), .ldst(rt_ldst), .ea(rt_ea), .data(rt_data),
      .mark(mark), .words(words), .nwords(nwords)
   );

   trace_alloc #(.DEPTH(DEPTH)) u_alloc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .fill_mode(fill_q),
      .rt_valid(rt_valid), .mark(mark), .nwords(nwords), .room(room),
      .push(push), .base(base), .ovf_inc(ovf_inc), .ptr(ptr),
      .en(en), .full(full), .wrapped(wrapped)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = {base[AW-1:0] + AW'(g), words[g]};
   end

   trace_hold_fifo #(.DW(QDW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_n(nwords),
      .push_data(lanes), .free(q_free), .pop_vld(q_vld), .pop_data(q_data)
   );

   trace_word_ram #(.AW(AW), .DW(32)) u_ram (
      .clk(clk), .we(q_vld), .waddr(q_data[QDW-1:32]), .wdata(q_data[31:0]),
      .raddr(bus_adr[AW-1:0]), .rdata(ram_q)
   );

   assign stat_word = (32'(ptr) << 16) | {28'b0, fill_q, wrapped, full, en};

   always_comb begin
      case (bus_adr[1:0])
         REG_CTRL: reg_mux = {31'b0, fill_q};
         REG_STAT: reg_mux = stat_word;
         REG_OVF:  reg_mux = 32'(ovf_q);
         default:  reg_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q     <= 1'b0;
         ack_q      <= 1'b0;
         rsel_ram_q <= 1'b0;
         reg_q      <= '0;
         ovf_q      <= '0;
      end else begin
         ack_q <= bus_go;
         if (bus_go) begin
            rsel_ram_q <= bus_adr[AW];
            reg_q      <= reg_mux;
         end
         if (ctrl_wr) fill_q <= bus_wdat[0];
         if (clr) ovf_q <= '0;
         else if (ovf_inc && ovf_q != '1) ovf_q <= ovf_q + OVF_W'(1);
      end
   end

   assign bus_ack  = ack_q;
   assign bus_rdat = rsel_ram_q ? ram_q : reg_q;

   logic unused_wdat;
   assign unused_wdat = ^bus_wdat[31:2];

   // R8
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);
   // R8
   ack_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> $past(bus_stb));
   // R10
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0 && !full && !wrapped && !en && ovf_q == '0));
   // R7
   ovf_only_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_inc && !clr) |=> $stable(ovf_q));
endmodule

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
   localparam int D   = 16;
   localparam int FD  = 8;
   localparam int AW  = 4;
   localparam int BAW = AW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rt_valid = 1'b0, rt_ldst = 1'b0;
   logic [31:0] rt_pc = '0, rt_insn = '0, rt_ea = '0, rt_data = '0;
   logic [1:0]  rt_mark = 2'b00;
   logic bus_stb = 1'b0, bus_we = 1'b0;
   logic [BAW-1:0] bus_adr = '0;
   logic [31:0] bus_wdat = '0;
   logic [31:0] bus_rdat;
   logic bus_ack;

   always #5 clk = ~clk;

   trace_capture_buf #(.DEPTH(D), .FIFO_DEPTH(FD), .OVF_W(16)) u_trace_capture_buf (
      .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_pc(rt_pc), .rt_insn(rt_insn),
      .rt_ldst(rt_ldst), .rt_ea(rt_ea), .rt_data(rt_data), .rt_mark(rt_mark),
      .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
      .bus_rdat(bus_rdat), .bus_ack(bus_ack)
   );

   int n_vec = 0, n_bad = 0, seq = 0;
   bit done = 1'b0;

   // arithmetic reference of the trace image
   int m_ptr, m_occ, m_ovf;
   bit m_en, m_full, m_wrap, m_fill;
   logic [31:0] m_mem [D];
   bit m_valid [D];

   always @(posedge clk) begin
      int occ0, n, base, pushed;
      bit fits;
      if (!rst_n) begin
         m_ptr = 0; m_occ = 0; m_ovf = 0;
         m_en = 0; m_full = 0; m_wrap = 0; m_fill = 0;
         for (int w = 0; w < D; w++) m_valid[w] = 1'b0;
      end else begin
         occ0 = m_occ; pushed = 0;
         if (bus_stb && bus_we && bus_adr == '0) begin
            m_fill = bus_wdat[0];
            if (bus_wdat[1]) begin
               m_ptr = 0; m_ovf = 0; m_en = 0; m_full = 0; m_wrap = 0; occ0 = 0;
            end
         end else if (rt_valid) begin
            if (m_en && (rt_mark == 2'b00 || rt_mark == 2'b11)) begin
               n = (rt_mark == 2'b00 && rt_ldst) ? 4 : 2;
               fits = (m_ptr + n) <= D;
               if (m_fill && (m_full || !fits)) m_full = 1'b1;
               else if (n <= FD - occ0) begin
                  base = fits ? m_ptr : 0;
                  if (!fits) m_wrap = 1'b1;
                  m_mem[base] = {rt_pc[31:2], (rt_mark == 2'b11) ? 2'b10 : (n == 4 ? 2'b01 : 2'b00)};
                  m_mem[base+1] = rt_insn;
                  if (n == 4) begin
                     m_mem[base+2] = rt_ea;
                     m_mem[base+3] = rt_data;
                  end
                  for (int j = 0; j < n; j++) m_valid[base+j] = 1'b1;
                  m_ptr = base + n;
                  pushed = n;
               end else m_ovf++;
            end
            if (rt_mark == 2'b01) m_en = 1'b1;
            if (rt_mark == 2'b10) m_en = 1'b0;
         end
         m_occ = occ0 + pushed - ((occ0 > 0) ? 1 : 0);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic retire(input logic ldst, input logic [1:0] mark);
      @(negedge clk);
      seq++;
      rt_valid = 1'b1; rt_ldst = ldst; rt_mark = mark;
      rt_pc   = 32'h0000_4000 + 32'(seq) * 4 + 32'(seq % 4);
      rt_insn = 32'h1500_0000 ^ 32'(seq * 7);
      rt_ea   = 32'h8000_0000 + 32'(seq) * 8;
      rt_data = ~32'(seq * 3);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         rt_valid = 1'b0; rt_mark = 2'b00;
      end
   endtask

   task automatic bus_wr(input logic [BAW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      rt_valid = 1'b0; rt_mark = 2'b00;
      bus_stb = 1'b1; bus_we = 1'b1; bus_adr = a; bus_wdat = d;
      @(negedge clk);
      bus_stb = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [BAW-1:0] a, output logic [31:0] d, output logic ack);
      @(negedge clk);
      rt_valid = 1'b0; rt_mark = 2'b00;
      bus_stb = 1'b1; bus_we = 1'b0; bus_adr = a;
      @(negedge clk);
      d = bus_rdat; ack = bus_ack;
      bus_stb = 1'b0;
   endtask

   task automatic check_all(input string req);
      logic [31:0] d;
      logic a;
      idle(FD + 3);
      bus_rd(5'd1, d, a);
      chk({req, " R9 status"}, d,
          (32'(m_ptr) << 16) | {28'b0, m_fill, m_wrap, m_full, m_en});
      chk("R8 ack with data", {31'b0, a}, 32'd1);
      bus_rd(5'd2, d, a);
      chk({req, " R7 overflow count"}, d, 32'(m_ovf));
      for (int w = 0; w < D; w++) begin
         if (m_valid[w]) begin
            bus_rd(5'(D + w), d, a);
            chk({req, " trace word"}, d, m_mem[w]);
         end
      end
   endtask

   initial begin
      logic [31:0] d;
      logic a;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 ack low in reset", {31'b0, bus_ack}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ack low after reset", {31'b0, bus_ack}, 32'd0);
      bus_rd(5'd1, d, a);
      chk("R11 status zero", d, 32'd0);
      @(negedge clk);
      chk("R8 ack is one-cycle pulse", {31'b0, bus_ack}, 32'd0);
      bus_rd(5'd2, d, a);
      chk("R11 overflow zero", d, 32'd0);

      // R3: capture off records nothing
      retire(1'b0, 2'b00); retire(1'b1, 2'b00); idle(1);
      check_all("R3 off");

      // R1 R2 R4: spaced mixed entries
      retire(1'b0, 2'b01); idle(2);
      retire(1'b0, 2'b00); idle(3);
      retire(1'b1, 2'b00); idle(3);
      retire(1'b1, 2'b11); idle(3);
      retire(1'b0, 2'b10); idle(2);
      retire(1'b0, 2'b00); idle(2);
      check_all("R1/R2/R4 formats");

      // R6: wrap mode run past the end
      retire(1'b0, 2'b01); idle(2);
      for (int k = 0; k < 5; k++) begin
         retire(1'b1, 2'b00); idle(4);
      end
      check_all("R6 wrap");

      // R10: clear with fill mode set
      bus_wr(5'd0, 32'd3);
      check_all("R10 clear");

      // R5: fill mode until full
      retire(1'b0, 2'b01); idle(2);
      for (int k = 0; k < 8; k++) begin
         retire(k[0], 2'b00); idle(4);
      end
      check_all("R5 fill");

      // R7: back-to-back load/stores overflow the queue
      bus_wr(5'd0, 32'd2);
      retire(1'b0, 2'b01);
      for (int k = 0; k < 6; k++) retire(1'b1, 2'b00);
      idle(1);
      check_all("R7 overflow");

      // sweep: both modes, entry mixes and gap patterns
      for (int md = 0; md < 2; md++) begin
         for (int pat = 0; pat < 8; pat++) begin
            bus_wr(5'd0, 32'(2 + md));
            retire(1'b0, 2'b01);
            for (int k = 0; k < 9; k++) begin
               retire(pat[k % 3], (k == 4 && pat[0]) ? 2'b11 : 2'b00);
               idle((pat + k) % 3);
            end
            check_all(md ? "R5/R7 sweep" : "R6/R7 sweep");
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule